// File: doc/BRIEF.md
# Dual-Issue In-Order Hazard Gate

This block is the issue controller of a two-wide, in-order pipeline that also retires its results in order. A decoded pair of instructions is handed over through a valid/ready handshake. Each instruction carries a destination register, two source registers, the class of functional unit it needs, an execution latency of one or two cycles and a branch marker. Once a pair sits in the block's two slots, the block decides each cycle which slots issue. For every issue it raises a strobe together with the index of the unit that takes the instruction.

Register hazards between the two members of a held pair are compared and reported on three flags: read-after-write, write-after-read and write-after-write. Three functional units each keep a small countdown of their remaining execution cycles. While any unit still has a multi-cycle operation running, all issue is held back, so results come out in program order. A new pair can only enter once both slots have drained.

Top module: `pair_issue_gate`

## Requirements
- R1: After reset `pairReady` is 1 and no issue strobe is high. `pairReady` is 1 exactly when both slots are empty. A pair is taken on a cycle where `pairValid` and `pairReady` are both 1, and `pairReady` is 0 on the cycles that follow until both slots have issued.
- R2: The slot-0 instruction of an accepted pair issues in the first cycle after acceptance, unless a unit is still counting down a multi-cycle operation.
- R3: Slot 1 never issues before slot 0. It issues together with slot 0 only when none of the delay conditions in R4, R5, R6, R9 or R10 applies. Otherwise it issues alone in a later cycle.
- R4: When both instructions name the same unit class (2-bit field, values 0 to 2), slot 1 issues one cycle after slot 0.
- R5: When a source of slot 1 equals the nonzero destination of slot 0, `hazRaw` is 1 while both slots are held, and slot 1 issues one cycle after slot 0.
- R6: When both destinations are equal and nonzero, `hazWaw` is 1 while both slots are held, and slot 1 issues one cycle after slot 0.
- R7: When the nonzero destination of slot 1 equals a source of slot 0, `hazWar` is 1 while both slots are held. This alone does not delay slot 1.
- R8: Register number 0 (5-bit register fields) never raises a hazard flag and never delays issue.
- R9: The latency field gives the execution cycles (1 or 2). After a 2-cycle instruction issues, no instruction issues in the next cycle. A slot-1 instruction behind a 2-cycle slot-0 instruction therefore issues two cycles after it.
- R10: When slot 0 is marked as a branch, slot 1 issues at the earliest one cycle after it.
- R11: `issue0Unit` and `issue1Unit` equal the unit class of the instruction being issued on the matching strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pairValid | input | 1 | A decoded pair is offered |
| pairReady | output | 1 | Both slots are empty; the offered pair is taken |
| s0Dst | input | 5 | Slot-0 destination register |
| s0SrcA | input | 5 | Slot-0 first source register |
| s0SrcB | input | 5 | Slot-0 second source register |
| s0Unit | input | 2 | Slot-0 unit class |
| s0Lat | input | 2 | Slot-0 latency in cycles |
| s0Branch | input | 1 | Slot-0 is a branch |
| s1Dst | input | 5 | Slot-1 destination register |
| s1SrcA | input | 5 | Slot-1 first source register |
| s1SrcB | input | 5 | Slot-1 second source register |
| s1Unit | input | 2 | Slot-1 unit class |
| s1Lat | input | 2 | Slot-1 latency in cycles |
| s1Branch | input | 1 | Slot-1 is a branch |
| issue0 | output | 1 | Slot-0 instruction issues this cycle |
| issue0Unit | output | 2 | Unit taking the slot-0 instruction |
| issue1 | output | 1 | Slot-1 instruction issues this cycle |
| issue1Unit | output | 2 | Unit taking the slot-1 instruction |
| hazRaw | output | 1 | Read-after-write hazard inside the held pair |
| hazWar | output | 1 | Write-after-read hazard inside the held pair |
| hazWaw | output | 1 | Write-after-write hazard inside the held pair |

## Verification
The hardest case to reach from the ports is the unit countdown stalling an issue. Because a new pair enters only after both slots have drained, a 2-cycle operation cannot hold back the next pair. The stall can only be seen between the two slots of one pair. The stimulus therefore places a 2-cycle instruction in slot 0 with an unrelated partner in slot 1, and checks that the partner waits through the stall cycle. It also sends a pair whose slot 1 is 2-cycle and follows it at once with another pair, to show that the countdown has ended before the next pair's slot 0 can issue.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;
  localparam int REG_W  = 5;
  localparam int UNIT_W = 2;
  localparam int LAT_W  = 2;

  typedef struct packed {
    logic [REG_W-1:0]  dst;
    logic [REG_W-1:0]  srcA;
    logic [REG_W-1:0]  srcB;
    logic [UNIT_W-1:0] unit;
    logic [LAT_W-1:0]  lat;
    logic              branch;
  } piInstr_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic issue0;
    logic issue1;
  } piStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic anyBusy;
    logic sameUnit;
    logic rawPair;
    logic warPair;
    logic wawPair;
    logic slot0Multi;
    logic slot0Branch;
  } piStatus_t;
endpackage

// File: rtl/pair_issue_dp.sv
module pair_issue_dp
  import pair_issue_pkg::*;
#(
  parameter int NUM_UNITS = 3,
  parameter int MAX_LAT   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  piStrobe_t         strobe,
  input  logic              held0,
  input  logic              held1,
  input  piInstr_t          in0,
  input  piInstr_t          in1,
  output piStatus_t         status,
  output logic [UNIT_W-1:0] issueUnit0,
  output logic [UNIT_W-1:0] issueUnit1,
  output logic              hazRaw,
  output logic              hazWar,
  output logic              hazWaw
);
  localparam int CNT_W = (MAX_LAT > 2) ? $clog2(MAX_LAT) : 1;

  piInstr_t pair0, pair1;
  logic [NUM_UNITS-1:0] busyVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pair0 <= '0;
      pair1 <= '0;
    end else if (strobe.load) begin
      pair0 <= in0;
      pair1 <= in1;
    end
  end

  logic dst0Live, dst1Live;
  assign dst0Live = (pair0.dst != '0);
  assign dst1Live = (pair1.dst != '0);

  always_comb begin
    status             = '0;
    status.anyBusy     = |busyVec;
    status.sameUnit    = (pair0.unit == pair1.unit);
    status.rawPair     = dst0Live && ((pair1.srcA == pair0.dst) || (pair1.srcB == pair0.dst));
    status.warPair     = dst1Live && ((pair1.dst == pair0.srcA) || (pair1.dst == pair0.srcB));
    status.wawPair     = dst0Live && (pair1.dst == pair0.dst);
    status.slot0Multi  = (pair0.lat > LAT_W'(1));
    status.slot0Branch = pair0.branch;
  end

  assign hazRaw     = held0 && held1 && status.rawPair;
  assign hazWar     = held0 && held1 && status.warPair;
  assign hazWaw     = held0 && held1 && status.wawPair;
  assign issueUnit0 = pair0.unit;
  assign issueUnit1 = pair1.unit;

  // per-unit countdown of extra execution cycles
  for (genvar u = 0; u < NUM_UNITS; u++) begin : gUnit
    logic [CNT_W-1:0] remain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        remain <= '0;
      end else if (strobe.issue0 && pair0.unit == UNIT_W'(u) && pair0.lat > LAT_W'(1)) begin
        remain <= CNT_W'(pair0.lat - LAT_W'(1));
      end else if (strobe.issue1 && pair1.unit == UNIT_W'(u) && pair1.lat > LAT_W'(1)) begin
        remain <= CNT_W'(pair1.lat - LAT_W'(1));
      end else if (remain != '0) begin
        remain <= remain - CNT_W'(1);
      end
    end
    assign busyVec[u] = (remain != '0);
  end

  // R9: a running multi-cycle unit blocks every issue
  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    status.anyBusy |-> (!strobe.issue0 && !strobe.issue1));
  // R9: issuing a 2-cycle op makes the next cycle a stall cycle
  a_r9_stall_after_multi: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue0 && pair0.lat == LAT_W'(2) && pair0.unit < UNIT_W'(NUM_UNITS)) |=> !strobe.issue0 && !strobe.issue1);
  // R5: a pair with a read-after-write never issues together
  a_r5_raw_split: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue0 && strobe.issue1) |-> !status.rawPair);
  // R6: a pair with a write-after-write never issues together
  a_r6_waw_split: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue0 && strobe.issue1) |-> !status.wawPair);
  // R4: two issues in one cycle always go to distinct units
  a_r4_distinct_units: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue0 && strobe.issue1) |-> (issueUnit0 != issueUnit1));
endmodule

// File: rtl/pair_issue_ctrl.sv
module pair_issue_ctrl
  import pair_issue_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pairValid,
  input  piStatus_t status,
  output logic      pairReady,
  output piStrobe_t strobe,
  output logic      held0,
  output logic      held1
);
  logic coIssueOk;

  assign pairReady = !held0 && !held1;
  assign coIssueOk = !status.sameUnit && !status.rawPair && !status.wawPair &&
                     !status.slot0Multi && !status.slot0Branch;

  always_comb begin
    strobe        = '0;
    strobe.load   = pairValid && pairReady;
    strobe.issue0 = held0 && !status.anyBusy;
    if (held0) strobe.issue1 = held1 && strobe.issue0 && coIssueOk;
    else       strobe.issue1 = held1 && !status.anyBusy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held0 <= 1'b0;
      held1 <= 1'b0;
    end else if (strobe.load) begin
      held0 <= 1'b1;
      held1 <= 1'b1;
    end else begin
      if (strobe.issue0) held0 <= 1'b0;
      if (strobe.issue1) held1 <= 1'b0;
    end
  end

  // R1: an accepted pair closes the input on the next cycle
  a_r1_accept_closes: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && pairReady) |=> !pairReady);
  // R1: nothing issues while the slots are empty
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    pairReady |-> (!strobe.issue0 && !strobe.issue1));
  // R3: slot 1 never overtakes a slot 0 that is still waiting
  a_r3_no_overtake: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue1 && held0) |-> strobe.issue0);
  // R10: a branch in slot 0 keeps slot 1 back by at least a cycle
  a_r10_branch_first: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue0 && status.slot0Branch) |-> !strobe.issue1);
endmodule

// File: rtl/pair_issue_gate.sv
module pair_issue_gate
  import pair_issue_pkg::*;
#(
  parameter int NUM_UNITS = 3,
  parameter int MAX_LAT   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pairValid,
  output logic              pairReady,
  input  logic [REG_W-1:0]  s0Dst,
  input  logic [REG_W-1:0]  s0SrcA,
  input  logic [REG_W-1:0]  s0SrcB,
  input  logic [UNIT_W-1:0] s0Unit,
  input  logic [LAT_W-1:0]  s0Lat,
  input  logic              s0Branch,
  input  logic [REG_W-1:0]  s1Dst,
  input  logic [REG_W-1:0]  s1SrcA,
  input  logic [REG_W-1:0]  s1SrcB,
  input  logic [UNIT_W-1:0] s1Unit,
  input  logic [LAT_W-1:0]  s1Lat,
  input  logic              s1Branch,
  output logic              issue0,
  output logic [UNIT_W-1:0] issue0Unit,
  output logic              issue1,
  output logic [UNIT_W-1:0] issue1Unit,
  output logic              hazRaw,
  output logic              hazWar,
  output logic              hazWaw
);
  piInstr_t  in0, in1;
  piStrobe_t strobe;
  piStatus_t status;
  logic      held0, held1;

  assign in0 = '{dst: s0Dst, srcA: s0SrcA, srcB: s0SrcB, unit: s0Unit, lat: s0Lat, branch: s0Branch};
  assign in1 = '{dst: s1Dst, srcA: s1SrcA, srcB: s1SrcB, unit: s1Unit, lat: s1Lat, branch: s1Branch};

  pair_issue_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .pairValid (pairValid),
    .status    (status),
    .pairReady (pairReady),
    .strobe    (strobe),
    .held0     (held0),
    .held1     (held1)
  );

  pair_issue_dp #(.NUM_UNITS(NUM_UNITS), .MAX_LAT(MAX_LAT)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .held0      (held0),
    .held1      (held1),
    .in0        (in0),
    .in1        (in1),
    .status     (status),
    .issueUnit0 (issue0Unit),
    .issueUnit1 (issue1Unit),
    .hazRaw     (hazRaw),
    .hazWar     (hazWar),
    .hazWaw     (hazWaw)
  );

  assign issue0 = strobe.issue0;
  assign issue1 = strobe.issue1;
endmodule

// File: tb/pair_issue_gate_test.sv
module pair_issue_gate_test;
  import pair_issue_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pairValid = 1'b0;
  logic pairReady, issue0, issue1, hazRaw, hazWar, hazWaw;
  logic [UNIT_W-1:0] issue0Unit, issue1Unit;
  piInstr_t drv0 = '0, drv1 = '0;

  int checks = 0, errors = 0, cyc = 0;
  bit running = 1'b0;

  typedef struct {
    int    when;
    int    slot;
    int    unit;
    string req;
  } expIssue_t;
  expIssue_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  pair_issue_gate uut (
    .clk(clk), .rstN(rstN), .pairValid(pairValid), .pairReady(pairReady),
    .s0Dst(drv0.dst), .s0SrcA(drv0.srcA), .s0SrcB(drv0.srcB),
    .s0Unit(drv0.unit), .s0Lat(drv0.lat), .s0Branch(drv0.branch),
    .s1Dst(drv1.dst), .s1SrcA(drv1.srcA), .s1SrcB(drv1.srcB),
    .s1Unit(drv1.unit), .s1Lat(drv1.lat), .s1Branch(drv1.branch),
    .issue0(issue0), .issue0Unit(issue0Unit), .issue1(issue1), .issue1Unit(issue1Unit),
    .hazRaw(hazRaw), .hazWar(hazWar), .hazWaw(hazWaw)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic piInstr_t mk(input int dst, input int a, input int b,
                                  input int unit, input int lat, input bit br);
    piInstr_t t;
    t.dst = REG_W'(dst); t.srcA = REG_W'(a); t.srcB = REG_W'(b);
    t.unit = UNIT_W'(unit); t.lat = LAT_W'(lat); t.branch = br;
    return t;
  endfunction

  // monitor: compare every issue strobe with the front of the queue
  task automatic popCheck(input int slot, input int unit);
    expIssue_t e;
    if (expQ.size() == 0) begin
      check(1'b0, "R3", "unexpected issue on slot", slot, -1);
    end else begin
      e = expQ.pop_front();
      check(e.when == cyc, e.req, "issue cycle", cyc, e.when);
      check(e.slot == slot, e.req, "issue slot", slot, e.slot);
      check(e.unit == unit, "R11", "issue unit", unit, e.unit);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (running) begin
      if (issue0) popCheck(0, int'(issue0Unit));
      if (issue1) popCheck(1, int'(issue1Unit));
    end
  end

  // driver: offer a pair, queue the expected issues, check the flags
  task automatic sendPair(input piInstr_t i0, input piInstr_t i1,
                          input int d0, input int d1, input int eFlags,
                          input string req);
    int a;
    expIssue_t e;
    @(negedge clk);
    while (!pairReady) @(negedge clk);
    drv0 = i0; drv1 = i1; pairValid = 1'b1;
    a = cyc;
    e.when = a + d0; e.slot = 0; e.unit = int'(i0.unit); e.req = req; expQ.push_back(e);
    e.when = a + d1; e.slot = 1; e.unit = int'(i1.unit); e.req = req; expQ.push_back(e);
    @(negedge clk);
    pairValid = 1'b0;
    #2;
    check({hazRaw, hazWar, hazWaw} == 3'(eFlags), req, "hazard flags {raw,war,waw}",
          int'({hazRaw, hazWar, hazWaw}), eFlags);
    check(pairReady == 1'b0, "R1", "ready while pair held", int'(pairReady), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pairReady == 1'b1, "R1", "reset ready", int'(pairReady), 1);
    check(issue0 == 1'b0, "R1", "reset issue0", int'(issue0), 0);
    check(issue1 == 1'b0, "R1", "reset issue1", int'(issue1), 0);
    rstN = 1'b1;
    running = 1'b1;
    @(negedge clk);
    // R2, R11: independent pair on distinct units issues together
    sendPair(mk(1,2,3,0,1,0),  mk(4,5,6,1,1,0),  1, 1, 3'b000, "R2");
    // R4: same unit class
    sendPair(mk(1,2,3,2,1,0),  mk(4,5,6,2,1,0),  1, 2, 3'b000, "R4");
    // R5: read-after-write through srcA, then srcB
    sendPair(mk(7,2,3,0,1,0),  mk(8,7,6,1,1,0),  1, 2, 3'b100, "R5");
    sendPair(mk(9,1,1,1,1,0),  mk(10,2,9,2,1,0), 1, 2, 3'b100, "R5");
    // R7: write-after-read only, no delay
    sendPair(mk(3,5,6,0,1,0),  mk(5,1,2,1,1,0),  1, 1, 3'b010, "R7");
    // R6: write-after-write
    sendPair(mk(12,1,2,0,1,0), mk(12,3,4,1,1,0), 1, 2, 3'b001, "R6");
    // R8: register 0 everywhere
    sendPair(mk(0,1,2,0,1,0),  mk(0,0,0,1,1,0),  1, 1, 3'b000, "R8");
    // R9: 2-cycle slot 0 holds slot 1 through the stall cycle
    sendPair(mk(13,1,2,1,2,0), mk(14,3,4,2,1,0), 1, 3, 3'b000, "R9");
    // R9: 2-cycle slot 1, next pair follows without stall
    sendPair(mk(15,1,2,0,1,0), mk(16,3,4,1,2,0), 1, 1, 3'b000, "R9");
    // R10: branch in slot 0
    sendPair(mk(0,1,2,2,1,1),  mk(17,3,4,0,1,0), 1, 2, 3'b000, "R10");
    // R5, R6, R7 together
    sendPair(mk(5,5,6,0,1,0),  mk(5,5,1,1,1,0),  1, 2, 3'b111, "R6");
    // R3: slot 1 waits behind same-unit slot 0 with a write-after-read
    sendPair(mk(20,21,22,1,1,0), mk(21,23,24,1,1,0), 1, 2, 3'b010, "R3");
    repeat (8) @(negedge clk);
    #2;
    check(expQ.size() == 0, "R3", "issues still outstanding", expQ.size(), 0);
    check(pairReady == 1'b1, "R1", "ready after drain", int'(pairReady), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule